// File: doc/BRIEF.md
# Buffered Serial Channel with Receive Flow Control

This block is one full-duplex asynchronous serial channel using 8 data bits, no parity and one stop bit. It holds a 16-byte ring on each side. The host writes bytes into the transmit ring with a push strobe. The transmitter drains that ring on its own, one frame after another. Bytes taken from the line are placed in the receive ring. The host removes them with a pop strobe. The host can watch occupancy counts and empty/full flags for both rings.

Bit timing comes from a host-supplied divisor, given as the number of `tick_i` pulses per bit period. The block counts only those cycles where `tick_i` is high, so one free-running tick generator can pace several channels. When the receive ring has no usable room left, the receiver drops the incoming byte, sets a sticky overrun flag, and drops its ready outputs to tell the far end to pause. The next host pop raises those outputs again.

Top module: `buf_uart_chan`

## Requirements
- R1: After reset `txd_o` is 1, `cts_o` and `dsr_o` are 1, `ovr_o` is 0, both counts are 0 and both empty flags are 1.
- R2: A frame on `txd_o` is one 0 start bit, then the 8 data bits starting with bit 0, then one 1 stop bit. Each bit lasts `div_i` ticks.
- R3: The transmitter starts queued bytes in push order. Frames follow back to back with no idle gap. `tx_count_o` drops by one as each frame starts, and it reaches 0 once all frames have started.
- R4: Timing advances only on cycles where `tick_i` is 1. While `tick_i` is 0, a waiting byte is not started and `txd_o` does not change.
- R5: The transmit ring holds at most 16 bytes. When `tx_count_o` is 16, `tx_full_o` is 1 and a push is ignored: the count does not change and the byte is never sent.
- R6: The receiver waits for a 0 on `rxd_i`. It then samples 1.5 bit periods later, and once per bit period after that. Eight samples form the byte, bit 0 first, and the ninth sample (the stop bit) is discarded. The byte is stored, `rx_count_o` rises by one, and `pop_data_o` shows the oldest stored byte.
- R7: When the receive ring is empty, `pop_data_o` is 0x00. A pop in that state changes neither the count nor `cts_o`/`dsr_o`.
- R8: `rx_full_o` is 1 when `rx_count_o` equals 15. A byte that completes in that state, with no pop in the same cycle, is dropped. The count stays at 15, `ovr_o` becomes 1, and `cts_o` and `dsr_o` become 0.
- R9: A pop from a non-empty receive ring removes the oldest byte, lowers the count by one, and sets `cts_o` and `dsr_o` to 1.
- R10: `ovr_o` stays at 1 until a cycle where `ovr_clr_i` is 1, and then clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing enable; one tick is one count of the bit timer |
| div_i | input | 16 | Ticks per bit period (2 or more) |
| push_i | input | 1 | Push a byte into the transmit ring |
| push_data_i | input | 8 | Byte to push |
| tx_full_o | output | 1 | Transmit ring holds 16 bytes |
| tx_empty_o | output | 1 | Transmit ring is empty |
| tx_count_o | output | 5 | Transmit ring occupancy |
| pop_i | input | 1 | Remove the oldest byte from the receive ring |
| pop_data_o | output | 8 | Oldest received byte, or 0x00 when empty |
| rx_full_o | output | 1 | Receive ring has no room for another byte (15 held) |
| rx_empty_o | output | 1 | Receive ring is empty |
| rx_count_o | output | 5 | Receive ring occupancy |
| ovr_o | output | 1 | Sticky overrun flag |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| cts_o | output | 1 | Ready-to-receive indication to the far end |
| dsr_o | output | 1 | Second ready indication, follows cts_o |

## Verification
The hardest state to reach from the ports is the overrun. To get there, the receive ring must hold exactly fifteen bytes, with no pop in between, at the moment another frame finishes. The stimulus sends fifteen serial frames with the host idle and confirms the count and `rx_full_o`. It then sends one more frame and confirms that this byte never appears. Finally it pops once and checks that the ready outputs come back while the overrun flag stays set. The refused transmit push is handled the same way: `tick_i` is held low so the ring can fill to sixteen without draining.

// File: rtl/buf_uart_pkg.sv
package buf_uart_pkg;
  typedef logic [7:0] byte_t;
  localparam int unsigned FRAME_BITS = 10;
  localparam int unsigned RX_SAMPLES = 9;
endpackage

// File: rtl/buf_ring.sv
module buf_ring #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic             full, push_ok, pop_ok;

  assign empty_o = (count_o == '0);
  assign full    = (count_o == CNT_W'(DEPTH));
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
    end else begin
      if (push_ok) wr_q <= adv(wr_q);
      if (pop_ok)  rd_q <= adv(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   count_o <= count_o + CNT_W'(1);
        2'b01:   count_o <= count_o - CNT_W'(1);
        default: count_o <= count_o;
      endcase
    end
  end

  AST_RING_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH)); // R5
  AST_FULL_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !pop_i) |=> (count_o == CNT_W'(DEPTH))); // R5
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o); // R7
endmodule

// File: rtl/buf_uart_tx.sv
module buf_uart_tx
  import buf_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ring_empty_i,
  input  byte_t            ring_data_i,
  output logic             ring_pop_o,
  output logic             txd_o
);
  localparam int unsigned BW = $clog2(FRAME_BITS + 1);

  logic [DIV_W-1:0]      tmr_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [BW-1:0]         left_q;
  logic                  busy_q, bnd, frame_end;

  assign bnd        = tick_i && (tmr_q == '0);
  assign frame_end  = !busy_q || (left_q == BW'(1));
  assign ring_pop_o = bnd && frame_end && !ring_empty_i;
  assign txd_o      = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (tick_i) begin
      tmr_q <= bnd ? div_i - DIV_W'(1) : tmr_q - DIV_W'(1);
      if (bnd) begin
        if (!frame_end) begin
          sh_q   <= {1'b1, sh_q[FRAME_BITS-1:1]};
          left_q <= left_q - BW'(1);
        end else if (!ring_empty_i) begin
          sh_q   <= {1'b1, ring_data_i, 1'b0};
          left_q <= BW'(FRAME_BITS);
          busy_q <= 1'b1;
        end else begin
          sh_q   <= '1;
          busy_q <= 1'b0;
        end
      end
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> txd_o); // R1
  AST_TX_EDGE_ON_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> $past(bnd)); // R4
endmodule

// File: rtl/buf_uart_rx.sv
module buf_uart_rx
  import buf_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rxd_i,
  output logic             done_o,
  output byte_t            data_o
);
  localparam int unsigned TW = DIV_W + 1;
  localparam int unsigned BW = $clog2(RX_SAMPLES + 1);

  logic [1:0]    sync_q;
  logic          rx_s, busy_q, smp;
  logic [TW-1:0] tmr_q;
  logic [BW-1:0] bits_q;

  assign rx_s = sync_q[1];
  assign smp  = tick_i && busy_q && (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      busy_q <= 1'b0;
      tmr_q  <= '0;
      bits_q <= '0;
      data_o <= '0;
      done_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      done_o <= 1'b0;
      if (tick_i) begin
        if (!busy_q) begin
          if (!rx_s) begin
            busy_q <= 1'b1;
            bits_q <= BW'(RX_SAMPLES);
            // one and a half bit periods to the centre of data bit 0
            tmr_q  <= TW'(div_i) + TW'(div_i >> 1) - TW'(1);
          end
        end else if (smp) begin
          tmr_q  <= TW'(div_i) - TW'(1);
          bits_q <= bits_q - BW'(1);
          if (bits_q == BW'(1)) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end else begin
            data_o <= {rx_s, data_o[7:1]};
          end
        end else begin
          tmr_q <= tmr_q - TW'(1);
        end
      end
    end
  end

  AST_RX_BITS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (bits_q >= BW'(1) && bits_q <= BW'(RX_SAMPLES))); // R6
  AST_RX_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
endmodule

// File: rtl/buf_uart_chan.sv
module buf_uart_chan
  import buf_uart_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DIV_W = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             push_i,
  input  logic [7:0]       push_data_i,
  output logic             tx_full_o,
  output logic             tx_empty_o,
  output logic [CNT_W-1:0] tx_count_o,
  input  logic             pop_i,
  output logic [7:0]       pop_data_o,
  output logic             rx_full_o,
  output logic             rx_empty_o,
  output logic [CNT_W-1:0] rx_count_o,
  output logic             ovr_o,
  input  logic             ovr_clr_i,
  input  logic             rxd_i,
  output logic             txd_o,
  output logic             cts_o,
  output logic             dsr_o
);
  byte_t tx_head, rx_head, rx_byte;
  logic  tx_pop, rx_done, pop_ok, drop, store, rdy_q;

  buf_ring #(.DEPTH(DEPTH), .W(8)) u_tx_ring (
    .clk_i, .rst_ni,
    .push_i (push_i),     .data_i (push_data_i),
    .pop_i  (tx_pop),     .data_o (tx_head),
    .count_o(tx_count_o), .empty_o(tx_empty_o)
  );

  buf_uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i, .rst_ni, .tick_i, .div_i,
    .ring_empty_i(tx_empty_o), .ring_data_i(tx_head),
    .ring_pop_o  (tx_pop),     .txd_o
  );

  buf_uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i, .rst_ni, .tick_i, .div_i, .rxd_i,
    .done_o(rx_done), .data_o(rx_byte)
  );

  buf_ring #(.DEPTH(DEPTH), .W(8)) u_rx_ring (
    .clk_i, .rst_ni,
    .push_i (store),      .data_i (rx_byte),
    .pop_i  (pop_i),      .data_o (rx_head),
    .count_o(rx_count_o), .empty_o(rx_empty_o)
  );

  assign tx_full_o  = (tx_count_o == CNT_W'(DEPTH));
  assign rx_full_o  = (rx_count_o == CNT_W'(DEPTH - 1));
  assign pop_ok     = pop_i && !rx_empty_o;
  assign drop       = rx_done && rx_full_o && !pop_ok;
  assign store      = rx_done && !drop;
  assign pop_data_o = rx_empty_o ? 8'h00 : rx_head;
  assign cts_o      = rdy_q;
  assign dsr_o      = rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b1;
      ovr_o <= 1'b0;
    end else begin
      if (drop)                rdy_q <= 1'b0;
      else if (store || pop_ok) rdy_q <= 1'b1;
      if (drop)           ovr_o <= 1'b1;
      else if (ovr_clr_i) ovr_o <= 1'b0;
    end
  end

  AST_DROP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> (ovr_o && !cts_o && !dsr_o)); // R8
  AST_DROP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> (rx_count_o == CNT_W'(DEPTH - 1))); // R8
  AST_POP_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_ok && !rx_done) |=> cts_o); // R9
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o); // R10
endmodule

// File: tb/sim_buf_uart_chan.sv
`timescale 1ns/1ps
module sim_buf_uart_chan;
  localparam int DIV = 10;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [15:0] div = 16'(DIV);
  logic push = 0, pop = 0, ovr_clr = 0, rxd = 1;
  logic [7:0] push_data = 0;
  logic tx_full, tx_empty, rx_full, rx_empty, ovr, txd, cts, dsr;
  logic [4:0] tx_count, rx_count;
  logic [7:0] pop_data;

  int checks = 0, bad = 0;
  bit done_flag = 0;
  bit mon_busy = 0;
  logic prev_txd = 1;
  logic [7:0] exp_q[$];
  logic [7:0] sent[$];

  always #2.5 clk = ~clk;

  buf_uart_chan u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .div_i(div),
    .push_i(push), .push_data_i(push_data), .tx_full_o(tx_full),
    .tx_empty_o(tx_empty), .tx_count_o(tx_count), .pop_i(pop),
    .pop_data_o(pop_data), .rx_full_o(rx_full), .rx_empty_o(rx_empty),
    .rx_count_o(rx_count), .ovr_o(ovr), .ovr_clr_i(ovr_clr),
    .rxd_i(rxd), .txd_o(txd), .cts_o(cts), .dsr_o(dsr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: queue the byte for the monitor when the ring accepts it
  task automatic push_tx(input logic [7:0] b);
    if (!tx_full) exp_q.push_back(b);
    push = 1; push_data = b;
    @(negedge clk);
    push = 0;
  endtask

  task automatic drain_tx();
    for (int i = 0; i < 30000 && (exp_q.size() != 0 || mon_busy); i++) @(negedge clk);
    cyc(3 * DIV);
  endtask

  task automatic send_rx(input logic [7:0] b);
    rxd = 0; cyc(DIV);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; cyc(DIV); end
    rxd = 1; cyc(DIV);
    cyc(2 * DIV);
  endtask

  task automatic pop_rx(input logic [7:0] exp, input string req);
    chk(pop_data == exp, req, pop_data, exp);
    pop = 1; @(negedge clk); pop = 0;
  endtask

  // monitor: decode frames on txd and compare against the queue (R2, R3)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && prev_txd && !txd) begin
        logic [7:0] got;
        logic [7:0] exp;
        bit have;
        mon_busy = 1;
        have = exp_q.size() != 0;
        exp = have ? exp_q.pop_front() : 8'h00;
        chk(have, "R5 unexpected frame", 1, 0);
        cyc(DIV / 2);
        chk(txd == 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin cyc(DIV); got[i] = txd; end
        cyc(DIV);
        chk(txd == 1'b1, "R2 stop bit", txd, 1);
        chk(got == exp, "R2 R3 frame data", got, exp);
        mon_busy = 0;
      end
      prev_txd = txd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      bad++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    cyc(4);
    chk(txd == 1 && cts == 1 && dsr == 1, "R1 lines", {txd, cts, dsr}, 3'b111);
    chk(ovr == 0, "R1 ovr", ovr, 0);
    chk(tx_count == 0 && rx_count == 0, "R1 counts", {tx_count, rx_count}, 0);
    chk(tx_empty && rx_empty, "R1 empty", {tx_empty, rx_empty}, 2'b11);
    rst_n = 1;
    cyc(2);

    // R4: no tick, no frame
    push_tx(8'h3A);
    cyc(60);
    chk(txd == 1, "R4 txd held", txd, 1);
    chk(tx_count == 1, "R4 byte waits", tx_count, 1);
    tick = 1;
    drain_tx();

    // R2/R3: several patterns back to back
    push_tx(8'h55); push_tx(8'h00); push_tx(8'hFF); push_tx(8'h81);
    cyc(DIV + 2);
    chk(tx_count == 3, "R3 count after first start", tx_count, 3);
    drain_tx();
    chk(tx_count == 0 && tx_empty, "R3 drained", tx_count, 0);

    // R5: fill the ring with timing frozen
    tick = 0;
    cyc(2);
    for (int i = 0; i < 16; i++) push_tx(8'(i * 7 + 1));
    chk(tx_full == 1, "R5 full flag", tx_full, 1);
    chk(tx_count == 16, "R5 count 16", tx_count, 16);
    push_tx(8'hEE);
    chk(tx_count == 16, "R5 refused push", tx_count, 16);
    tick = 1;
    drain_tx();
    cyc(300);
    chk(tx_count == 0, "R5 only 16 sent", tx_count, 0);

    // R7: pop on empty
    chk(pop_data == 8'h00, "R7 empty data", pop_data, 0);
    pop = 1; @(negedge clk); pop = 0;
    chk(rx_count == 0 && cts == 1 && dsr == 1, "R7 no change", rx_count, 0);

    // R6: receive a few bytes
    send_rx(8'hA5); send_rx(8'h3C); send_rx(8'h01);
    chk(rx_count == 3, "R6 count", rx_count, 3);
    pop_rx(8'hA5, "R6 first");
    pop_rx(8'h3C, "R6 second");
    pop_rx(8'h01, "R6 third");
    chk(rx_empty == 1, "R6 empty after pops", rx_empty, 1);

    // R8: overrun on the sixteenth byte
    for (int i = 0; i < 15; i++) begin
      sent.push_back(8'(8'hC0 ^ (i * 13)));
      send_rx(8'(8'hC0 ^ (i * 13)));
    end
    chk(rx_count == 15 && rx_full == 1, "R8 count 15", rx_count, 15);
    chk(cts == 1 && ovr == 0, "R8 still ready", {cts, ovr}, 2'b10);
    send_rx(8'h77);
    chk(rx_count == 15, "R8 byte dropped", rx_count, 15);
    chk(ovr == 1, "R8 ovr set", ovr, 1);
    chk(cts == 0 && dsr == 0, "R8 ready low", {cts, dsr}, 0);

    // R9: pop re-asserts ready
    pop_rx(sent.pop_front(), "R9 oldest");
    chk(cts == 1 && dsr == 1, "R9 ready high", {cts, dsr}, 2'b11);
    chk(rx_count == 14, "R9 count", rx_count, 14);

    // R10: sticky until cleared
    cyc(20);
    chk(ovr == 1, "R10 sticky", ovr, 1);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk(ovr == 0, "R10 cleared", ovr, 0);

    while (sent.size() != 0) pop_rx(sent.pop_front(), "R6 order after overrun");
    chk(rx_empty == 1 && pop_data == 0, "R7 empty again", pop_data, 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule